// File: doc/BRIEF.md
# Rotor Lock Protection Timer

This block guards a three-phase brushless drive against a stalled rotor. While the drive is active, it watches the Hall sensor bits. If the rotor stops producing Hall transitions for longer than a programmed number of timer ticks, the block latches a lock fault. The fault removes permission for the high-side switches. The timeout is counted in ticks from an internal prescaler, which stands in for the slow timing oscillator of an analog controller. Every change seen on the synchronized Hall bits restarts the count.

The count runs only while the drive is enabled. Braking freezes it, so the protection does nothing while the windings are shorted. The fault does not go away by itself. It is released by one of two things: a stop request held for a minimum number of clocks, or a zero-duty request held across a minimum number of ticks. A one-cycle expiry flag is also produced, so that reverse-rotation protection can reuse the same timebase. Reset clears all state and withdraws high-side permission for as long as it is asserted.

Top module: `rotor_lock_guard`

## Requirements
- R1: With `drive_en` high, `brake` low and no fault latched, `lock_fault` sets on the `timeout_ticks`-th tick after the timer restarts. A tick occurs once every PRESCALE clocks. A change on `hall_raw` restarts the timer at the third rising clock edge after it, because of two synchronizer stages and one compare stage.
- R2: A change in any Hall bit restarts the count from zero. If the bits change at intervals shorter than the timeout, the fault never sets.
- R3: While `drive_en` is low, the count is held at zero and no expiry can happen.
- R4: While `brake` is high, the count is frozen and no expiry can happen. When `brake` falls, counting resumes from the frozen value rather than from zero.
- R5: Once set, `lock_fault` stays set whatever the Hall, drive or brake inputs do. No further expiry pulses appear until the fault is released.
- R6: `hs_allow` is low whenever `lock_fault` is high.
- R7: `timer_expired` is a pulse one clock wide. It is high in the same cycle in which `lock_fault` rises.
- R8: `stop` held high for STOP_CYCLES consecutive rising edges clears `lock_fault` and the timer. A hold that is one edge shorter leaves the fault set.
- R9: `duty_zero` held high across ZERO_TICKS ticks clears `lock_fault` and the timer. A hold that covers fewer ticks leaves the fault set.
- R10: A `timeout_ticks` value of zero disables expiry completely.
- R11: While `rst_n` is low, `lock_fault`, `timer_expired` and `hs_allow` are all low. After release, `hs_allow` goes high when no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; blocks drive while low |
| hall_raw | input | HALL_W | Unsynchronized Hall sensor bits |
| drive_en | input | 1 | Motor is being driven |
| brake | input | 1 | Short-brake active; freezes the timer |
| stop | input | 1 | Stop request; a long enough hold releases the fault |
| duty_zero | input | 1 | Commanded duty is zero; a long enough hold releases the fault |
| timeout_ticks | input | TIMEOUT_W | Lock timeout in prescaled ticks; 0 disables it |
| lock_fault | output | 1 | Latched rotor-lock fault |
| timer_expired | output | 1 | One-cycle pulse when the timeout elapses |
| hs_allow | output | 1 | High-side switches permitted |

## Verification
The hardest case to reach from the ports is a brake that lands in the middle of a count. The test must show that counting resumes from the frozen value and does not restart, while the prescaler phase cannot be seen from outside. The stimulus anchors the timer with a Hall change, lets exactly five tick periods pass, and then holds the brake for longer than a whole timeout. After the brake is released, the fault must rise within the window for the remaining five ticks. That window closes before a fresh timeout could finish. The release conditions are also tested one step short of their thresholds to expose off-by-one errors in the hold counters.

// File: rtl/rlg_pkg.sv
package rlg_pkg;
  // Per-cycle action chosen for the lock timeout counter.
  typedef enum logic [2:0] {
    TMR_IDLE,     // held at zero: not driving, fault latched, or release
    TMR_FROZEN,   // brake active, keep value
    TMR_RESTART,  // Hall activity seen
    TMR_STEP,     // prescaled tick, advance
    TMR_WAIT      // no tick this cycle
  } tmr_act_e;
endpackage

// File: rtl/rlg_tick_gen.sv
module rlg_tick_gen #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every_clock
      logic on_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= 1'b1;
      end
      assign tick = on_q;
    end else begin : g_divider
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/rlg_hall_sync.sv
module rlg_hall_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hall_raw,
  output logic         hall_changed
);
  logic [STAGES-1:0][W-1:0] sh_q;
  logic [W-1:0]             last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= '0;
    end else begin
      sh_q[0] <= hall_raw;
      for (int i = 1; i < int'(STAGES); i++) sh_q[i] <= sh_q[i-1];
      last_q <= sh_q[STAGES-1];
    end
  end

  assign hall_changed = (sh_q[STAGES-1] != last_q);
endmodule

// File: rtl/rlg_clear_qual.sv
module rlg_clear_qual #(
  parameter int unsigned STOP_CYCLES = 500,
  parameter int unsigned ZERO_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stop,
  input  logic duty_zero,
  output logic clear_req
);
  localparam int unsigned SW = $clog2(STOP_CYCLES + 1);
  localparam int unsigned ZW = $clog2(ZERO_TICKS + 1);
  localparam logic [SW-1:0] STOP_DONE = SW'(STOP_CYCLES);
  localparam logic [ZW-1:0] ZERO_DONE = ZW'(ZERO_TICKS);

  logic [SW-1:0] stop_run_q;
  logic [ZW-1:0] zero_run_q;

  // consecutive clocks with stop asserted, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     stop_run_q <= '0;
    else if (!stop)                 stop_run_q <= '0;
    else if (stop_run_q != STOP_DONE) stop_run_q <= stop_run_q + 1'b1;
  end

  // ticks seen while zero duty is held, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              zero_run_q <= '0;
    else if (!duty_zero)                     zero_run_q <= '0;
    else if (tick && zero_run_q != ZERO_DONE) zero_run_q <= zero_run_q + 1'b1;
  end

  assign clear_req = (stop_run_q == STOP_DONE) || (zero_run_q == ZERO_DONE);
endmodule

// File: rtl/rlg_lock_timer.sv
module rlg_lock_timer
  import rlg_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hall_changed,
  input  logic          drive_en,
  input  logic          brake,
  input  logic          clear_req,
  input  logic [TW-1:0] timeout_ticks,
  output logic          lock_fault,
  output logic          timer_expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW:0]   cnt_inc;
  logic          fault_q, expired_q, hit;
  tmr_act_e      act;

  always_comb begin
    if (clear_req || !drive_en || fault_q) act = TMR_IDLE;
    else if (brake)                        act = TMR_FROZEN;
    else if (hall_changed)                 act = TMR_RESTART;
    else if (tick)                         act = TMR_STEP;
    else                                   act = TMR_WAIT;
  end

  assign cnt_inc = {1'b0, cnt_q} + (TW+1)'(1);
  assign hit = (act == TMR_STEP) && (timeout_ticks != '0) &&
               (cnt_inc >= {1'b0, timeout_ticks});

  always_comb begin
    case (act)
      TMR_IDLE, TMR_RESTART: cnt_d = '0;
      TMR_STEP:              cnt_d = hit ? '0 : cnt_inc[TW-1:0];
      default:               cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      fault_q   <= 1'b0;
      expired_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      fault_q   <= clear_req ? 1'b0 : (fault_q | hit);
      expired_q <= hit;
    end
  end

  assign lock_fault    = fault_q;
  assign timer_expired = expired_q;
endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard #(
  parameter int unsigned PRESCALE    = 1000,
  parameter int unsigned HALL_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_W   = 16,
  parameter int unsigned STOP_CYCLES = 500,
  parameter int unsigned ZERO_TICKS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HALL_W-1:0]    hall_raw,
  input  logic                 drive_en,
  input  logic                 brake,
  input  logic                 stop,
  input  logic                 duty_zero,
  input  logic [TIMEOUT_W-1:0] timeout_ticks,
  output logic                 lock_fault,
  output logic                 timer_expired,
  output logic                 hs_allow
);
  logic tick, hall_changed, clear_req;

  rlg_tick_gen #(.DIV(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rlg_hall_sync #(.W(HALL_W), .STAGES(SYNC_STAGES)) u_hall (
    .clk(clk), .rst_n(rst_n), .hall_raw(hall_raw), .hall_changed(hall_changed)
  );

  rlg_clear_qual #(.STOP_CYCLES(STOP_CYCLES), .ZERO_TICKS(ZERO_TICKS)) u_clr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop),
    .duty_zero(duty_zero), .clear_req(clear_req)
  );

  rlg_lock_timer #(.TW(TIMEOUT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hall_changed(hall_changed),
    .drive_en(drive_en), .brake(brake), .clear_req(clear_req),
    .timeout_ticks(timeout_ticks), .lock_fault(lock_fault),
    .timer_expired(timer_expired)
  );

  // high side is only permitted out of reset and with no latched fault
  assign hs_allow = rst_n & ~lock_fault;
endmodule

// File: rtl/rlg_checker.sv
module rlg_checker #(
  parameter int unsigned TW          = 16,
  parameter int unsigned STOP_CYCLES = 500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drive_en,
  input logic          brake,
  input logic          stop,
  input logic          duty_zero,
  input logic [TW-1:0] timeout_ticks,
  input logic          lock_fault,
  input logic          timer_expired,
  input logic          hs_allow
);
  localparam int unsigned SW = $clog2(STOP_CYCLES + 1);
  localparam logic [SW-1:0] HELD = SW'(STOP_CYCLES);
  logic [SW-1:0] stop_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  stop_seen_q <= '0;
    else if (!stop)              stop_seen_q <= '0;
    else if (stop_seen_q != HELD) stop_seen_q <= stop_seen_q + 1'b1;
  end

  p_pulse_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expired |=> !timer_expired);
  p_rise_with_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fault) |-> timer_expired);
  p_hs_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fault |-> !hs_allow);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> !timer_expired);
  p_brake_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brake |=> !timer_expired);
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_ticks == '0) |=> !timer_expired);
  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_fault && !stop && !$past(stop) && !duty_zero && !$past(duty_zero))
      |=> lock_fault);
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen_q == HELD) |=> !lock_fault);
endmodule

bind rotor_lock_guard rlg_checker #(.TW(TIMEOUT_W), .STOP_CYCLES(STOP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .brake(brake), .stop(stop),
  .duty_zero(duty_zero), .timeout_ticks(timeout_ticks), .lock_fault(lock_fault),
  .timer_expired(timer_expired), .hs_allow(hs_allow)
);

// File: tb/rotor_lock_guard_tb.sv
module rotor_lock_guard_tb;
  localparam int P  = 4;
  localparam int T  = 10;
  localparam int S  = 5;
  localparam int Z  = 3;
  localparam int TW = 8;

  logic clk = 1'b0;
  always #10ns clk = ~clk;

  logic          rst_n = 1'b0;
  logic [2:0]    hall_raw = '0;
  logic          drive_en = 1'b0, brake = 1'b0, stop = 1'b0, duty_zero = 1'b0;
  logic [TW-1:0] timeout_ticks = TW'(T);
  logic          lock_fault, timer_expired, hs_allow;

  rotor_lock_guard #(
    .PRESCALE(P), .HALL_W(3), .SYNC_STAGES(2), .TIMEOUT_W(TW),
    .STOP_CYCLES(S), .ZERO_TICKS(Z)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_raw(hall_raw), .drive_en(drive_en),
    .brake(brake), .stop(stop), .duty_zero(duty_zero),
    .timeout_ticks(timeout_ticks), .lock_fault(lock_fault),
    .timer_expired(timer_expired), .hs_allow(hs_allow)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  int q_lo[$];
  int q_hi[$];
  logic fault_prev = 1'b0, exp_prev = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard entry: the fault must rise within [lo, hi] cycles from now
  task automatic expect_rise(int lo, int hi);
    q_lo.push_back(cyc + lo);
    q_hi.push_back(cyc + hi);
  endtask

  // advance n falling edges, then act 2 ns later
  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #2ns;
  endtask

  function automatic logic [2:0] next_hall(logic [2:0] h);
    return {h[1:0], ~h[2]};
  endfunction

  // monitor: compares fault rises against the expected windows
  always @(negedge clk) begin
    int lo, hi;
    cyc++;
    if (rst_n) begin
      if (lock_fault && !fault_prev) begin
        check(timer_expired === 1'b1, "R7 expiry flag with fault rise", int'(timer_expired), 1);
        if (q_lo.size() == 0) check(1'b0, "R1 unexpected fault rise", cyc, 0);
        else begin
          lo = q_lo.pop_front();
          hi = q_hi.pop_front();
          check(cyc >= lo && cyc <= hi, "R1 fault rise cycle", cyc, lo);
        end
      end
      if (timer_expired && exp_prev) check(1'b0, "R7 pulse wider than one cycle", 2, 1);
      if (timer_expired && fault_prev) check(1'b0, "R5 expiry while latched", 1, 0);
      if (q_hi.size() > 0 && cyc > q_hi[0]) begin
        check(1'b0, "R1 fault missing by cycle", cyc, q_hi[0]);
        void'(q_lo.pop_front());
        void'(q_hi.pop_front());
      end
    end
    fault_prev = lock_fault;
    exp_prev   = timer_expired;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R11: reset state
    check(lock_fault == 1'b0, "R11 fault in reset", int'(lock_fault), 0);
    check(timer_expired == 1'b0, "R11 expiry in reset", int'(timer_expired), 0);
    check(hs_allow == 1'b0, "R11 hs_allow in reset", int'(hs_allow), 0);
    rst_n = 1'b1;
    idle(2);
    check(hs_allow == 1'b1, "R11 hs_allow after reset", int'(hs_allow), 1);

    // R1/R7: plain timeout after a Hall change
    drive_en = 1'b1;
    hall_raw = next_hall(hall_raw);
    expect_rise(3 + (T-1)*P + 1, 3 + T*P);
    idle(3 + T*P + 2);
    check(lock_fault == 1'b1, "R1 fault after timeout", int'(lock_fault), 1);
    check(hs_allow == 1'b0, "R6 hs_allow with fault", int'(hs_allow), 0);
    check(timer_expired == 1'b0, "R7 pulse ended", int'(timer_expired), 0);

    // R5: Hall activity and brake do not release the latch
    for (int i = 0; i < 4; i++) begin
      hall_raw = next_hall(hall_raw);
      idle(P*2);
    end
    brake = 1'b1; idle(3); brake = 1'b0;
    idle(T*P);
    check(lock_fault == 1'b1, "R5 latch holds", int'(lock_fault), 1);

    // R8: stop one edge short, then long enough
    drive_en = 1'b0;
    stop = 1'b1; idle(S-1); stop = 1'b0;
    idle(4);
    check(lock_fault == 1'b1, "R8 short stop ignored", int'(lock_fault), 1);
    stop = 1'b1; idle(S); stop = 1'b0;
    idle(2);
    check(lock_fault == 1'b0, "R8 stop release", int'(lock_fault), 0);
    check(hs_allow == 1'b1, "R6 hs_allow after release", int'(hs_allow), 1);

    // R2: periodic Hall changes keep the fault away
    drive_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      hall_raw = next_hall(hall_raw);
      idle((T-2)*P);
      check(lock_fault == 1'b0, "R2 changes restart timer", int'(lock_fault), 0);
    end
    // R3: not driving, no fault however long
    drive_en = 1'b0;
    idle(3*T*P);
    check(lock_fault == 1'b0, "R3 idle when not driving", int'(lock_fault), 0);

    // R4: brake mid-count freezes then resumes
    drive_en = 1'b1;
    hall_raw = next_hall(hall_raw);
    idle(3 + 5*P);
    brake = 1'b1;
    idle(3*T*P);
    check(lock_fault == 1'b0, "R4 no expiry during brake", int'(lock_fault), 0);
    brake = 1'b0;
    expect_rise(4*P + 1, 5*P);
    idle(4*P);
    check(lock_fault == 1'b0, "R4 resume not early", int'(lock_fault), 0);
    idle(P + 2);
    check(lock_fault == 1'b1, "R4 resumed count expires", int'(lock_fault), 1);

    // R9: zero duty short hold, then long enough
    drive_en = 1'b0;
    duty_zero = 1'b1; idle((Z-1)*P); duty_zero = 1'b0;
    idle(3);
    check(lock_fault == 1'b1, "R9 short zero duty ignored", int'(lock_fault), 1);
    duty_zero = 1'b1; idle(Z*P + 2); duty_zero = 1'b0;
    idle(2);
    check(lock_fault == 1'b0, "R9 zero duty release", int'(lock_fault), 0);

    // R10: timeout of zero disables expiry
    timeout_ticks = '0;
    drive_en = 1'b1;
    hall_raw = next_hall(hall_raw);
    idle(200);
    check(lock_fault == 1'b0, "R10 zero timeout disabled", int'(lock_fault), 0);

    // R1: short timeout pattern
    timeout_ticks = TW'(3);
    hall_raw = next_hall(hall_raw);
    expect_rise(3 + 2*P + 1, 3 + 3*P);
    idle(3 + 3*P + 2);
    check(lock_fault == 1'b1, "R1 short timeout", int'(lock_fault), 1);

    // R11: reset clears a latched fault
    rst_n = 1'b0;
    idle(2);
    check(lock_fault == 1'b0, "R11 reset clears fault", int'(lock_fault), 0);
    check(hs_allow == 1'b0, "R11 no drive in reset", int'(hs_allow), 0);
    drive_en = 1'b0;
    rst_n = 1'b1;
    idle(4);
    check(q_lo.size() == 0, "R1 pending windows", q_lo.size(), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule